// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block lets a synchronous host read and write one external asynchronous static RAM of 262,144 four-bit words. The host presents an access on a request/acknowledge port: address, write flag and write data, qualified by a valid signal and accepted when the controller reports ready. The controller then drives the RAM's address, active-low chip select and active-low write strobe. It controls the output-enable for its side of the shared four-bit data bus and decides the clock edge on which returned read data is sampled.

Each timing interval is a whole number of clock cycles set by a parameter: the read wait, the width of the write strobe, and an idle gap placed between a read and a following write. Writes are controlled by the write strobe. The controller drives the data pins only inside the strobe-low window: it starts one cycle after the strobe falls and stops on the edge that raises it. The RAM's output driver and the controller's driver are therefore never on at the same time. Pad buffering is left to the chip level. The block exposes the bus as separate in, out and enable signals.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, ram_ce_n and ram_we_n are 1, ram_dq_oe is 0 and rsp_valid is 0. Once reset is released, req_ready is 1.
- R2: An accepted read holds ram_ce_n at 0 and ram_we_n at 1 for RD_WAIT cycles. The value on ram_dq_in in the last of those cycles is returned on rsp_rdata, together with a rsp_valid pulse exactly one cycle wide, RD_WAIT+1 cycles after the accepting edge.
- R3: An accepted write holds ram_ce_n and ram_we_n at 0 for exactly WR_PULSE cycles, with ram_addr and the driven data stable throughout. The write is acknowledged by a one-cycle rsp_valid pulse WR_PULSE+1 cycles after the accepting edge when no turnaround applies.
- R4: ram_dq_oe is 0 in the first cycle of the write strobe and 1 in every later strobe cycle (WR_PULSE-1 cycles). It falls on the same edge that raises ram_we_n and is never 1 while ram_we_n or ram_ce_n is 1.
- R5: A write that directly follows a read first spends TURN_CYC cycles with ram_ce_n and ram_we_n both 1. Its acknowledge then comes TURN_CYC+WR_PULSE+1 cycles after the accepting edge. A write that follows a write gets no turnaround.
- R6: req_ready is 0 from the edge that accepts a request until the access completes. A request presented while req_ready is 0 is not taken and writes nothing to the RAM.
- R7: At no clock cycle do the RAM (ram_ce_n 0 with ram_we_n 1) and the controller (ram_dq_oe 1) both drive the data bus.
- R8: Every word read back equals the last word written to that address, for addresses at both ends of the range and alternating bit patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller can take a request this cycle |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| ram_addr | output | ADDR_W | RAM address pins |
| ram_ce_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_dq_out | output | DATA_W | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Drive enable for the data pins |
| ram_dq_in | input | DATA_W | Data pin value seen from the RAM |

## Verification
The hardest case to reach from the ports is a write that immediately follows a read. In that case the turnaround gap and the delayed drive enable together must keep the two drivers apart. The stimulus table places writes directly after reads, and writes after writes, at several address patterns. A behavioural RAM model in the bench drives the bus whenever it is selected for reading, and it counts every cycle in which both sides drive. A directed case holds a conflicting write request for the whole of a read, then reads the target back to show that the request was never taken.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_TURN  = 2'd2,
    ST_WRITE = 2'd3
  } sram_st_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_WAIT  = 2,
  parameter int WR_PULSE = 2,
  parameter int TURN_CYC = 1,
  parameter int CNT_W    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  output sram_st_e         state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_WAIT - 1);
  localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_PULSE - 1);
  localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'((TURN_CYC > 0) ? TURN_CYC - 1 : 0);
  localparam logic             HAS_TURN  = (TURN_CYC > 0);

  sram_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last_rd_q, last_rd_d;
  logic             rd_end, wr_end, turn_end;

  assign rd_end   = (st_q == ST_READ)  && (cnt_q == RD_LAST);
  assign wr_end   = (st_q == ST_WRITE) && (cnt_q == WR_LAST);
  assign turn_end = (st_q == ST_TURN)  && (cnt_q == TURN_LAST);

  // next-state logic
  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    last_rd_d = last_rd_q;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (req_valid) begin
          if (req_write) begin
            st_d = (HAS_TURN && last_rd_q) ? ST_TURN : ST_WRITE;
          end else begin
            st_d = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (rd_end) begin
          st_d      = ST_IDLE;
          cnt_d     = '0;
          last_rd_d = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_TURN: begin
        if (turn_end) begin
          st_d  = ST_WRITE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_WRITE: begin
        if (wr_end) begin
          st_d      = ST_IDLE;
          cnt_d     = '0;
          last_rd_d = 1'b0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      last_rd_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      last_rd_q <= last_rd_d;
    end
  end

  assign state_o   = st_q;
  assign cnt_o     = cnt_q;
  assign accept_o  = (st_q == ST_IDLE) && req_valid;
  assign capture_o = rd_end;
  assign done_o    = rd_end || wr_end;

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 4,
  parameter int CNT_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  sram_st_e          state,
  input  logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_ce_n,
  output logic              ram_we_n,
  output logic              ram_dq_oe
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdat_q, wdat_d;

  // hold request fields for the whole access (clock enable = accept)
  always_comb begin
    addr_d = addr_q;
    wdat_d = wdat_q;
    if (accept) begin
      addr_d = req_addr;
      wdat_d = req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else begin
      addr_q <= addr_d;
      wdat_q <= wdat_d;
    end
  end

  // pin decode from the registered state
  assign ram_addr   = addr_q;
  assign ram_dq_out = wdat_q;
  assign ram_ce_n   = !((state == ST_READ) || (state == ST_WRITE));
  assign ram_we_n   = (state != ST_WRITE);
  assign ram_dq_oe  = (state == ST_WRITE) && (cnt != '0);

endmodule

// File: rtl/sram_rsp_capture.sv
module sram_rsp_capture #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              done,
  input  logic [DATA_W-1:0] ram_dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic              vld_q;

  always_comb begin
    rdat_d = rdat_q;
    if (capture) begin
      rdat_d = ram_dq_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdat_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      rdat_q <= rdat_d;
      vld_q  <= done;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_rdata = rdat_q;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 4,
  parameter int RD_WAIT  = 2,
  parameter int WR_PULSE = 2,
  parameter int TURN_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_we_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);

  localparam int MAXC  = max3(RD_WAIT, WR_PULSE, TURN_CYC);
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

  logic             rst_int_n;
  sram_st_e         state;
  logic [CNT_W-1:0] cnt;
  logic             accept, capture, done;

  sram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  sram_ctrl_fsm #(
    .RD_WAIT  (RD_WAIT),
    .WR_PULSE (WR_PULSE),
    .TURN_CYC (TURN_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .state_o   (state),
    .cnt_o     (cnt),
    .accept_o  (accept),
    .capture_o (capture),
    .done_o    (done)
  );

  sram_pin_drive #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .state      (state),
    .cnt        (cnt),
    .ram_addr   (ram_addr),
    .ram_dq_out (ram_dq_out),
    .ram_ce_n   (ram_ce_n),
    .ram_we_n   (ram_we_n),
    .ram_dq_oe  (ram_dq_oe)
  );

  sram_rsp_capture #(
    .DATA_W (DATA_W)
  ) u_rsp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .capture   (capture),
    .done      (done),
    .ram_dq_in (ram_dq_in),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  assign req_ready = (state == ST_IDLE) && rst_int_n;

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_ce_n,
  input logic              ram_we_n,
  input logic [DATA_W-1:0] ram_dq_out,
  input logic              ram_dq_oe
);

  // R4: drive only inside the select-and-strobe window
  p_oe_inside_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> (!ram_we_n && !ram_ce_n));

  // R4: no drive in the cycle the strobe falls
  p_oe_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_we_n) |-> !ram_dq_oe);

  // R3: address held across the strobe
  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we_n && $past(!ram_we_n)) |-> $stable(ram_addr));

  // R3: driven data held while driving
  p_data_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_dq_oe && $past(ram_dq_oe)) |-> $stable(ram_dq_out));

  // R2: acknowledge is a single-cycle pulse
  p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R5: strobe never falls right after a read cycle
  p_no_read_to_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ram_ce_n && ram_we_n) |-> ram_we_n);

  // R6: accepted request makes the controller busy
  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R6: ready only when RAM is deselected
  p_ready_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_ce_n && ram_we_n && !ram_dq_oe));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .ram_addr   (ram_addr),
  .ram_ce_n   (ram_ce_n),
  .ram_we_n   (ram_we_n),
  .ram_dq_out (ram_dq_out),
  .ram_dq_oe  (ram_dq_oe)
);

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
module sram_async_ctrl_bench;

  localparam int AW  = 18;
  localparam int DW  = 4;
  localparam int RDW = 2;
  localparam int WRP = 2;
  localparam int TRN = 1;
  localparam int NVEC = 15;

  // {write, address, data}; read entries carry no data
  localparam logic [AW+DW:0] VEC [NVEC] = '{
    {1'b1, 18'h00000, 4'h5},
    {1'b1, 18'h3FFFF, 4'hA},
    {1'b0, 18'h00000, 4'h0},
    {1'b0, 18'h3FFFF, 4'h0},
    {1'b1, 18'h15555, 4'h3},
    {1'b1, 18'h2AAAA, 4'hC},
    {1'b0, 18'h15555, 4'h0},
    {1'b0, 18'h2AAAA, 4'h0},
    {1'b1, 18'h00000, 4'hF},
    {1'b0, 18'h00000, 4'h0},
    {1'b0, 18'h12345, 4'h0},
    {1'b1, 18'h12345, 4'h9},
    {1'b0, 18'h12345, 4'h0},
    {1'b1, 18'h3FFFF, 4'h0},
    {1'b0, 18'h3FFFF, 4'h0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] ram_addr;
  logic          ram_ce_n, ram_we_n, ram_dq_oe;
  logic [DW-1:0] ram_dq_out;
  logic [DW-1:0] ram_dq_in = '0;

  int errors = 0;
  int checks = 0;
  int contention = 0;
  int oe_bad = 0;
  bit prev_rd = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sram_async_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .RD_WAIT(RDW), .WR_PULSE(WRP), .TURN_CYC(TRN)
  ) u_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
    .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .ram_dq_out(ram_dq_out),
    .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  // behavioural RAM model and shadow
  logic [DW-1:0] ram_mem [logic [AW-1:0]];
  logic [DW-1:0] shadow  [logic [AW-1:0]];
  bit            pend_v = 1'b0;
  logic [AW-1:0] pend_a = '0;
  logic [DW-1:0] pend_d = '0;

  function automatic logic [DW-1:0] mem_get(input logic [AW-1:0] a);
    return ram_mem.exists(a) ? ram_mem[a] : '0;
  endfunction

  function automatic logic [DW-1:0] shadow_get(input logic [AW-1:0] a);
    return shadow.exists(a) ? shadow[a] : '0;
  endfunction

  // write takes effect when the select/strobe overlap ends
  always @(posedge clk) begin
    if (!ram_ce_n && !ram_we_n && ram_dq_oe) begin
      pend_v = 1'b1;
      pend_a = ram_addr;
      pend_d = ram_dq_out;
    end else if (pend_v && (ram_we_n || ram_ce_n)) begin
      ram_mem[pend_a] = pend_d;
      pend_v = 1'b0;
    end
  end

  // read drive and bus monitors, evaluated mid-cycle
  always @(negedge clk) begin
    if (!ram_ce_n && ram_we_n) ram_dq_in = mem_get(ram_addr);
    else                       ram_dq_in = '0;
    if (rst_n) begin
      if (!ram_ce_n && ram_we_n && ram_dq_oe) contention++;
      if (ram_dq_oe && (ram_we_n || ram_ce_n)) oe_bad++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // one access; junk_hold keeps a conflicting write request up while busy
  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit junk_hold, output logic [DW-1:0] rd);
    int lat, we_cnt, oe_cnt, exp_lat;
    bit turn;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    turn = wr && prev_rd && (TRN > 0);
    lat = 0; we_cnt = 0; oe_cnt = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        chk(req_ready == 1'b0, "R6 ready low while busy", req_ready, 0);
        if (turn) chk(ram_ce_n && ram_we_n, "R5 turnaround idle pins",
                      {ram_ce_n, ram_we_n}, 3);
        if (junk_hold) begin
          req_write = 1'b1; req_addr = a; req_wdata = ~mem_get(a);
        end else begin
          req_valid = 1'b0;
        end
      end
      if (!ram_we_n) we_cnt++;
      if (ram_dq_oe) oe_cnt++;
    end while (!rsp_valid && lat < 50);
    req_valid = 1'b0;
    rd = rsp_rdata;
    exp_lat = wr ? (WRP + 1 + (turn ? TRN : 0)) : (RDW + 1);
    if (wr) begin
      chk(lat == exp_lat, turn ? "R5 write latency after read" : "R3 write latency",
          lat, exp_lat);
      chk(we_cnt == WRP, "R3 strobe width", we_cnt, WRP);
      chk(oe_cnt == WRP - 1, "R4 drive cycles", oe_cnt, WRP - 1);
      shadow[a] = d;
    end else begin
      chk(lat == exp_lat, "R2 read latency", lat, exp_lat);
      chk(rd == shadow_get(a), "R8 read data", rd, shadow_get(a));
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 pulse one cycle", rsp_valid, 0);
    prev_rd = !wr;
  endtask

  initial begin
    logic [DW-1:0] rd;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(ram_ce_n && ram_we_n && !ram_dq_oe && !rsp_valid, "R1 pins in reset",
        {ram_ce_n, ram_we_n, ram_dq_oe, rsp_valid}, 4'hC);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ram_ce_n && ram_we_n && !ram_dq_oe && !rsp_valid, "R1 pins after reset",
        {ram_ce_n, ram_we_n, ram_dq_oe, rsp_valid}, 4'hC);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

    // table walk: R2 R3 R4 R5 R8
    for (int i = 0; i < NVEC; i++) begin
      access(VEC[i][AW+DW], VEC[i][AW+DW-1:DW], VEC[i][DW-1:0], 1'b0, rd);
    end

    // R6: conflicting write held for the whole read must not be taken
    access(1'b1, 18'h0ABCD, 4'h6, 1'b0, rd);
    access(1'b0, 18'h0ABCD, 4'h0, 1'b1, rd);
    access(1'b0, 18'h0ABCD, 4'h0, 1'b0, rd);
    chk(rd == 4'h6, "R6 busy request ignored", rd, 4'h6);

    // R7: no cycle with both drivers on; R4 drive outside strobe
    chk(contention == 0, "R7 bus contention cycles", contention, 0);
    chk(oe_bad == 0, "R4 drive outside strobe", oe_bad, 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

endmodule